// File: doc/BRIEF.md
# Sixty-Four Source Vectored Interrupt Controller

This block gathers up to sixty-four interrupt sources and presents them to a processor. Each source has its own control byte, which enables it, picks how it is detected (level, rising edge, falling edge or either edge) and sends it to one of eight destinations. Those destinations are the normal interrupt line, the fast interrupt line and six auxiliary lines. Every source input passes through a synchronizer before detection. The result lands in a status array that software reads as two 32-bit words. Software clears edge-captured bits by writing ones to them.

For the two processor lines, the block keeps a priority register that gives the number of the winning pending source. The search is either fixed, where the lowest number wins, or rotating, where it starts one past the source that was last handed out. A source counts as handed out when software reads the priority register while that source is the winner. When nothing is pending, the priority register reads the highest source number. Software therefore confirms that number against its status bit.

Register access uses a simple synchronous port. There is an address, write data, a write strobe with a byte/word selector, and a read strobe. Read data is combinational from the address.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all control bytes read 0x00, both status words read 0, every output is low, and both priority registers read 0x0000003F.
- R2: With control bits 6:5 equal to 00 (level), a source's status bit follows its synchronized input. Writing one to it has no effect, and it clears by itself when the input goes low.
- R3: Control bit 5 captures rising edges, bit 6 captures falling edges, and both set capture either edge. A captured bit stays set until a one is written to bit n%32 of the status word at 0x80 (sources 0-31) or 0x84 (sources 32-63).
- R4: A source whose control bit 3 is clear still latches status, but never drives any output and never appears in a priority register.
- R5: Control bits 2:0 route the source: 0 to irq_o, 1 to fiq_o, 2..7 to aux_o[0]..aux_o[5]. Each output is high while at least one enabled, pending source is routed to it.
- R6: The priority register at 0x20 serves irq_o and the one at 0x24 serves fiq_o. Bits 5:0 give the winner, or 63 when nothing routed there is pending. Bit 6 is a writable rotate-enable that reads back.
- R7: With rotate-enable clear, the lowest-numbered enabled pending source wins, and repeated reads return the same number.
- R8: With rotate-enable set, a read-strobed access to the priority register records the reported winner. The next search starts one above it and wraps from 63 to 0. Before the first record, the search starts at 0.
- R9: A byte write (bus_byte=1) changes only the byte at bus_addr, using bus_wdata[7:0]. A word write changes the four bytes of the aligned word. Control byte n reads in bits 8*(n%4)+7:8*(n%4) of the word at 0x40+4*(n/4).
- R10: When source 63 is the true winner, the priority register also reads 63. Bit 31 of the word at 0x84 is then set, and it is clear when nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 64 | Raw interrupt source inputs |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_byte | input | 1 | 1 = byte write, 0 = word write |
| bus_re | input | 1 | Read strobe, used to record rotation grants |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| aux_o | output | 6 | Auxiliary destination requests |

## Verification
The hardest state to reach is a rotating arbiter whose grant pointer has moved past several sources and then wraps from the top of the range back to low numbers. Only read-strobed accesses move that pointer. The stimulus therefore holds three level sources high, at numbers low, middle and high, switches the register to rotate, and reads it repeatedly until the reported number returns to the lowest source. A separate scenario makes the top source truly pending, so that the priority value 63 has to be told apart from the idle value by its status bit.

// File: rtl/vic_pkg.sv
package vic_pkg;
   // control byte layout
   localparam int CTL_EN_BIT   = 3;
   localparam int CTL_RISE_BIT = 5;
   localparam int CTL_FALL_BIT = 6;
   localparam int CTL_DST_W    = 3;
   // priority register layout
   localparam int PRI_ROT_BIT  = 6;
   localparam int PRI_IDX_W    = 6;
   // register offsets
   localparam logic [7:0] OFS_PRI_IRQ = 8'h20;
   localparam logic [7:0] OFS_PRI_FIQ = 8'h24;
   localparam logic [7:0] OFS_CTL     = 8'h40;
   localparam logic [7:0] OFS_STAT_LO = 8'h80;
   localparam logic [7:0] OFS_STAT_HI = 8'h84;
   // destinations
   localparam int NUM_DEST = 8;
   localparam int NUM_AUX  = 6;
   localparam int NUM_PRI  = 2;
   typedef enum logic [CTL_DST_W-1:0] {
      DST_IRQ  = 3'd0,
      DST_FIQ  = 3'd1,
      DST_AUX0 = 3'd2
   } dest_e;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic rise_en,
   input  logic fall_en,
   input  logic clr_i,
   output logic status_o
);
   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;
   logic                   synced;
   logic                   hit;
   logic                   edge_mode;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q <= '0;
            else        chain_q <= raw_i;
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
      end
   endgenerate

   assign synced    = chain_q[SYNC_STAGES-1];
   assign edge_mode = rise_en | fall_en;
   assign hit       = (rise_en & synced & ~prev_q) | (fall_en & ~synced & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= 1'b0;
         status_o <= 1'b0;
      end else begin
         prev_q <= synced;
         if (edge_mode) status_o <= (status_o & ~clr_i) | hit;
         else           status_o <= synced;
      end
   end
endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
   parameter int N     = 64,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   input  logic             rotate,
   input  logic [IDX_W-1:0] last,
   output logic             valid,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] start;
   logic [IDX_W-1:0] cand;

   always_comb begin
      start = rotate ? last + IDX_W'(1) : '0;
      valid = 1'b0;
      idx   = IDX_W'(N - 1);
      cand  = '0;
      // walk downward so the smallest offset from start is kept last
      for (int i = N - 1; i >= 0; i--) begin
         cand = start + IDX_W'(i);
         if (req[cand]) begin
            valid = 1'b1;
            idx   = cand;
         end
      end
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import vic_pkg::*;
#(
   parameter int NUM_SRC     = 64,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  src_i,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_we,
   input  logic                bus_byte,
   input  logic                bus_re,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq_o,
   output logic                fiq_o,
   output logic [NUM_AUX-1:0]  aux_o
);
   localparam int IDX_W   = $clog2(NUM_SRC);
   localparam int LANES   = DATA_W / 8;
   localparam int MAP_SRC = 64;

   // elaboration-time parameter checks
   generate
      if (NUM_SRC < 2 || NUM_SRC > MAP_SRC || (1 << IDX_W) != NUM_SRC) begin : g_bad_src
         $error("NUM_SRC must be a power of two between 2 and 64");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be at least 8");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("DATA_W must be 32");
      end
   endgenerate

   // ---------------- bus decode ----------------
   logic [ADDR_W-1:0] waddr;
   logic [LANES-1:0]  be;
   logic [DATA_W-1:0] wd;
   logic [DATA_W-1:0] bmask;
   logic              wr_stat_lo, wr_stat_hi;

   assign waddr = {bus_addr[ADDR_W-1:2], 2'b00};

   always_comb begin
      if (bus_byte) begin
         be = LANES'(1) << bus_addr[1:0];
         wd = {LANES{bus_wdata[7:0]}};
      end else begin
         be = '1;
         wd = bus_wdata;
      end
      for (int l = 0; l < LANES; l++) bmask[8*l +: 8] = {8{be[l]}};
   end

   assign wr_stat_lo = bus_we && (waddr == ADDR_W'(OFS_STAT_LO));
   assign wr_stat_hi = bus_we && (waddr == ADDR_W'(OFS_STAT_HI));

   // ---------------- control bytes ----------------
   logic [NUM_SRC-1:0][7:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (bus_we) begin
         for (int n = 0; n < NUM_SRC; n++) begin
            if (waddr == ADDR_W'(OFS_CTL) + ADDR_W'(4 * (n / 4)) && be[n % 4])
               ctrl_q[n] <= wd[8*(n % 4) +: 8];
         end
      end
   end

   // ---------------- acknowledge vector ----------------
   logic [2*DATA_W-1:0] clr_wide;
   logic [NUM_SRC-1:0]  clr;

   assign clr_wide[DATA_W-1:0]        = wr_stat_lo ? (wd & bmask) : '0;
   assign clr_wide[2*DATA_W-1:DATA_W] = wr_stat_hi ? (wd & bmask) : '0;
   assign clr                         = clr_wide[NUM_SRC-1:0];

   // ---------------- per-source detection ----------------
   logic [NUM_SRC-1:0] status_q;

   generate
      for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
         vic_src_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (src_i[n]),
            .rise_en  (ctrl_q[n][CTL_RISE_BIT]),
            .fall_en  (ctrl_q[n][CTL_FALL_BIT]),
            .clr_i    (clr[n]),
            .status_o (status_q[n])
         );
      end
   endgenerate

   // ---------------- routing ----------------
   logic [NUM_DEST-1:0][NUM_SRC-1:0] req;

   generate
      for (genvar d = 0; d < NUM_DEST; d++) begin : g_dst
         for (genvar n = 0; n < NUM_SRC; n++) begin : g_bit
            assign req[d][n] = status_q[n] & ctrl_q[n][CTL_EN_BIT]
                             & (ctrl_q[n][CTL_DST_W-1:0] == CTL_DST_W'(d));
         end
      end
      for (genvar k = 0; k < NUM_AUX; k++) begin : g_aux
         assign aux_o[k] = |req[k + int'(DST_AUX0)];
      end
   endgenerate

   assign irq_o = |req[DST_IRQ];
   assign fiq_o = |req[DST_FIQ];

   // ---------------- priority registers ----------------
   logic [NUM_PRI-1:0]            rot_q;
   logic [NUM_PRI-1:0][IDX_W-1:0] last_q;
   logic [NUM_PRI-1:0]            pvalid;
   logic [NUM_PRI-1:0][IDX_W-1:0] pidx;
   logic [NUM_PRI-1:0][ADDR_W-1:0] pri_ofs;

   assign pri_ofs[0] = ADDR_W'(OFS_PRI_IRQ);
   assign pri_ofs[1] = ADDR_W'(OFS_PRI_FIQ);

   generate
      for (genvar p = 0; p < NUM_PRI; p++) begin : g_pri
         vic_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
            .req    (req[p]),
            .rotate (rot_q[p]),
            .last   (last_q[p]),
            .valid  (pvalid[p]),
            .idx    (pidx[p])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rot_q[p]  <= 1'b0;
               last_q[p] <= IDX_W'(NUM_SRC - 1);
            end else begin
               if (bus_we && waddr == pri_ofs[p] && be[0])
                  rot_q[p] <= wd[PRI_ROT_BIT];
               if (bus_re && waddr == pri_ofs[p] && pvalid[p])
                  last_q[p] <= pidx[p];
            end
         end
      end
   endgenerate

   // ---------------- read mux ----------------
   logic [MAP_SRC-1:0]      stat_pad;
   logic [MAP_SRC-1:0][7:0] ctrl_pad;
   logic                    in_ctrl;

   always_comb begin
      stat_pad = '0;
      ctrl_pad = '0;
      for (int n = 0; n < NUM_SRC; n++) begin
         stat_pad[n] = status_q[n];
         ctrl_pad[n] = ctrl_q[n];
      end
   end

   assign in_ctrl = (waddr >= ADDR_W'(OFS_CTL)) && (waddr < ADDR_W'(OFS_CTL) + ADDR_W'(MAP_SRC));

   always_comb begin
      bus_rdata = '0;
      if (waddr == pri_ofs[0]) begin
         bus_rdata[PRI_IDX_W-1:0] = PRI_IDX_W'(pidx[0]);
         bus_rdata[PRI_ROT_BIT]   = rot_q[0];
      end else if (waddr == pri_ofs[1]) begin
         bus_rdata[PRI_IDX_W-1:0] = PRI_IDX_W'(pidx[1]);
         bus_rdata[PRI_ROT_BIT]   = rot_q[1];
      end else if (waddr == ADDR_W'(OFS_STAT_LO)) begin
         bus_rdata = stat_pad[DATA_W-1:0];
      end else if (waddr == ADDR_W'(OFS_STAT_HI)) begin
         bus_rdata = stat_pad[2*DATA_W-1:DATA_W];
      end else if (in_ctrl) begin
         for (int l = 0; l < LANES; l++)
            bus_rdata[8*l +: 8] = ctrl_pad[{waddr[5:2], 2'(l)}];
      end
   end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int NUM_SRC = 64,
   parameter int IDX_W   = $clog2(NUM_SRC)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_SRC-1:0]      status,
   input logic [NUM_SRC-1:0][7:0] ctrl,
   input logic                    irq_o,
   input logic                    fiq_o,
   input logic [IDX_W-1:0]        irq_idx,
   input logic [IDX_W-1:0]        fiq_idx,
   input logic                    irq_rot,
   input logic                    bus_we
);
   logic [NUM_SRC-1:0] irq_req_c;
   logic [NUM_SRC-1:0] below_mask;

   always_comb begin
      for (int n = 0; n < NUM_SRC; n++)
         irq_req_c[n] = status[n] && ctrl[n][3] && (ctrl[n][2:0] == 3'd0);
      below_mask = (NUM_SRC'(1) << irq_idx) - NUM_SRC'(1);
   end

   AST_IRQ_WINNER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (status[irq_idx] && ctrl[irq_idx][3] && ctrl[irq_idx][2:0] == 3'd0)); // R5

   AST_IRQ_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> irq_idx == IDX_W'(NUM_SRC - 1)); // R6

   AST_FIQ_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      !fiq_o |-> fiq_idx == IDX_W'(NUM_SRC - 1)); // R6

   AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_rot) |-> (irq_req_c & below_mask) == '0); // R7

   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req_c == '0) |-> !irq_o); // R4

   generate
      for (genvar n = 0; n < NUM_SRC; n++) begin : g_sticky
         AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (status[n] && (ctrl[n][5] || ctrl[n][6]) && !bus_we) |=> status[n]); // R3
      end
   endgenerate
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .status  (status_q),
   .ctrl    (ctrl_q),
   .irq_o   (irq_o),
   .fiq_o   (fiq_o),
   .irq_idx (pidx[0]),
   .fiq_idx (pidx[1]),
   .irq_rot (rot_q[0]),
   .bus_we  (bus_we)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src_i = '0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_byte = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq_o, fiq_o;
   logic [5:0]  aux_o;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   irq_vector_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_byte(bus_byte),
      .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o),
      .fiq_o(fiq_o), .aux_o(aux_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; src_i = '0; bus_we = 1'b0; bus_re = 1'b0; bus_byte = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic byte_m);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_byte = byte_m; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      rd(8'h20, v); chk("R1 irq prio", v, 32'h3F);
      rd(8'h24, v); chk("R1 fiq prio", v, 32'h3F);
      rd(8'h80, v); chk("R1 stat lo", v, 0);
      rd(8'h84, v); chk("R1 stat hi", v, 0);
      rd(8'h7C, v); chk("R1 ctrl word", v, 0);
      chk("R1 outputs", {24'd0, irq_o, fiq_o, aux_o}, 0);
   endtask

   task automatic t_level();
      logic [31:0] v;
      do_reset();
      wr(8'h45, 32'h08, 1'b1);
      src_i[5] = 1'b1; cyc(5);
      rd(8'h80, v); chk("R2 level set", v, 32'h20);
      chk("R2 irq high", {31'd0, irq_o}, 1);
      wr(8'h80, 32'h20, 1'b0);
      rd(8'h80, v); chk("R2 ack ignored", v, 32'h20);
      src_i[5] = 1'b0; cyc(5);
      rd(8'h80, v); chk("R2 level clear", v, 0);
      chk("R2 irq low", {31'd0, irq_o}, 0);
   endtask

   task automatic t_edge();
      logic [31:0] v;
      do_reset();
      wr(8'h4A, 32'h28, 1'b1);
      src_i[10] = 1'b1; cyc(5); src_i[10] = 1'b0; cyc(5);
      rd(8'h80, v); chk("R3 rise sticky", v, 32'h400);
      wr(8'h81, 32'h04, 1'b1);
      rd(8'h80, v); chk("R3 byte ack", v, 0);
      wr(8'h68, 32'h48, 1'b1);
      wr(8'h69, 32'h68, 1'b1);
      src_i[40] = 1'b1; cyc(5);
      rd(8'h84, v); chk("R3 fall waits", v, 0);
      src_i[40] = 1'b0; cyc(5);
      rd(8'h84, v); chk("R3 fall caught", v, 32'h100);
      src_i[41] = 1'b1; cyc(5);
      rd(8'h84, v); chk("R3 either edge", v, 32'h300);
      wr(8'h84, 32'h300, 1'b0);
      rd(8'h84, v); chk("R3 word ack", v, 0);
   endtask

   task automatic t_enable();
      logic [31:0] v;
      do_reset();
      wr(8'h47, 32'h20, 1'b1);
      src_i[7] = 1'b1; cyc(5);
      rd(8'h80, v); chk("R4 latch while off", v, 32'h80);
      chk("R4 no output", {24'd0, irq_o, fiq_o, aux_o}, 0);
      rd(8'h20, v); chk("R4 not reported", v, 32'h3F);
      wr(8'h47, 32'h28, 1'b1);
      chk("R4 enable asserts", {31'd0, irq_o}, 1);
      rd(8'h20, v); chk("R4 reported", v, 32'h07);
   endtask

   task automatic t_route();
      logic [31:0] v;
      do_reset();
      wr(8'h41, 32'h09, 1'b1);
      wr(8'h54, 32'h0D0C0B0A, 1'b0);
      rd(8'h54, v); chk("R9 word readback", v, 32'h0D0C0B0A);
      src_i[1] = 1'b1; cyc(5);
      chk("R5 fiq only", {24'd0, irq_o, fiq_o, aux_o}, 32'h40);
      rd(8'h24, v); chk("R6 fiq prio", v, 32'h01);
      rd(8'h20, v); chk("R6 irq idle", v, 32'h3F);
      src_i[22] = 1'b1; cyc(5);
      chk("R5 aux2", {26'd0, aux_o}, 32'h04);
      src_i[23] = 1'b1; cyc(5);
      chk("R5 aux3", {26'd0, aux_o}, 32'h0C);
   endtask

   task automatic t_fixed();
      logic [31:0] v;
      do_reset();
      wr(8'h43, 32'h08, 1'b1);
      wr(8'h49, 32'h08, 1'b1);
      wr(8'h72, 32'h08, 1'b1);
      src_i[3] = 1'b1; src_i[9] = 1'b1; src_i[50] = 1'b1; cyc(5);
      rd(8'h20, v); chk("R7 lowest", v, 32'h03);
      rd(8'h20, v); chk("R7 stays", v, 32'h03);
      src_i[3] = 1'b0; cyc(5);
      rd(8'h20, v); chk("R7 next lowest", v, 32'h09);
   endtask

   task automatic t_rotate();
      logic [31:0] v;
      do_reset();
      wr(8'h43, 32'h08, 1'b1);
      wr(8'h49, 32'h08, 1'b1);
      wr(8'h72, 32'h08, 1'b1);
      src_i[3] = 1'b1; src_i[9] = 1'b1; src_i[50] = 1'b1; cyc(5);
      wr(8'h20, 32'h40, 1'b0);
      rd(8'h20, v); chk("R8 first", v, 32'h43);
      rd(8'h20, v); chk("R8 second", v, 32'h49);
      rd(8'h20, v); chk("R8 third", v, 32'h72);
      rd(8'h20, v); chk("R8 wrap", v, 32'h43);
      rd(8'h24, v); chk("R8 fiq untouched", v, 32'h3F);
   endtask

   task automatic t_bus();
      logic [31:0] v;
      do_reset();
      wr(8'h41, 32'hFFFFFF28, 1'b1);
      wr(8'h43, 32'h48, 1'b1);
      rd(8'h40, v); chk("R9 byte lanes", v, 32'h48002800);
      wr(8'h44, 32'h11223344, 1'b0);
      rd(8'h44, v); chk("R9 word write", v, 32'h11223344);
      wr(8'h22, 32'h40, 1'b1);
      rd(8'h20, v); chk("R9 lane2 no rotate", v, 32'h3F);
   endtask

   task automatic t_top_src();
      logic [31:0] v;
      do_reset();
      wr(8'h7F, 32'h08, 1'b1);
      rd(8'h20, v); chk("R10 idle reads 63", v, 32'h3F);
      rd(8'h84, v); chk("R10 idle bit31", v, 0);
      src_i[63] = 1'b1; cyc(5);
      rd(8'h20, v); chk("R10 real 63", v, 32'h3F);
      rd(8'h84, v); chk("R10 bit31 set", v, 32'h80000000);
      chk("R10 irq", {31'd0, irq_o}, 1);
   endtask

   initial begin
      #(4 * 100000);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_level();
      t_edge();
      t_enable();
      t_route();
      t_fixed();
      t_rotate();
      t_bus();
      t_top_src();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule